// File: doc/BRIEF.md
# Thirty-Two Pin General-Purpose Port with Group Interrupts

The block is a general-purpose I/O port with 32 pins. Software reaches it through a word-wide register port and sets up several things there: the direction of each pin, an optional inversion of each input, and a value register. The value register drives the output pins and also records the sampled input pins. Two alias addresses set or clear output bits without a read-modify-write. Each input pin passes through a two-flop synchronizer and then an optional inversion. After that its stored value is watched for rising transitions, and each rising transition latches a cause bit.

The pins form four groups of eight. Each group has one interrupt request that goes to a parent interrupt aggregator. A pin raises its group request when its cause event occurs and its mask bit is set. One global mode bit selects how a request is released. In sticky edge mode, software releases a request by rewriting the cause register. In level-follow mode, the request drops once every stored value bit of the group is low again.

Top module: `gpio_port`

## Requirements
- R1: After reset, direction, polarity, value, cause, mask and the mode flag are all zero, `pin_out` is zero and `grp_irq` is zero.
- R2: Direction bit 1 marks an output pin. A write to the value register (address 2) loads only the output pins. Input pins ignore the write and keep tracking their inputs.
- R3: A write to the set alias (address 3) ORs the data into the output pins, and a write to the clear alias (address 4) clears the output pins whose data bits are 1. Input pins are not touched by either alias, and both aliases read as zero.
- R4: When a pin's polarity bit (address 1) is 1, its synchronized input level is inverted before it is stored in the value register.
- R5: An input change reaches the value register on the third rising clock edge after it is applied, and not earlier.
- R6: A rising transition of an input pin's stored value sets that pin's cause bit (address 5). If the pin's mask bit is 1, the same transition raises request `grp_irq[pin/8]` at that edge.
- R7: A rising transition on a pin whose mask bit is 0 sets the cause bit but raises no request.
- R8: In level-follow mode, a group request drops at the edge where a falling input leaves all eight of the group's value bits at zero. While any value bit of the group is still 1, the request stays high.
- R9: The control register (address 8) reads 0x11FF0000 with bit 10 equal to the mode flag. Writing bit 10 as 1 selects level-follow mode, and writing it as 0 selects edge mode.
- R10: A write to the cause register replaces its contents. In edge mode, a request stays high after its pin falls. It is released only by a cause write in which the group's cause bits change and all become zero, and a cause write that leaves any of the group's bits set keeps the request high.
- R11: Addresses 6 and 7 both access one shared 32-bit mask register.
- R12: In level-follow mode, a write to the cause register does not release a group request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Value register, drives output pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| grp_irq | output | 4 | One interrupt request per 8-pin group |

## Verification
A register write takes effect at the next rising edge, and reads are combinational, so the bench writes at a falling edge and reads back at the falling edge that follows. A pin change becomes visible in the value, cause and request outputs only at the third rising edge. The bench therefore checks for the absence of the change after two edges and for its presence after three. Mode tests and release tests wait four cycles after each pin change, so every sample falls clear of the synchronizer delay and away from any active edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_POL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_VAL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAUSE = 4'd5;
  localparam logic [ADDR_W-1:0] A_MSKA  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MSKB  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;

  localparam int MODE_BIT = 10;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } out_op_e;

  // next state of one output pin under a software operation
  function automatic logic out_bit_next(logic cur, logic wd, out_op_e op);
    case (op)
      OP_LOAD: return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  // fixed pattern of the control word with the mode flag folded in
  function automatic logic [31:0] ctrl_word(logic lvl_mode);
    logic [31:0] w;
    w = 32'h11FF_0000;
    w[MODE_BIT] = lvl_mode;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/gpio_grp_req.sv
module gpio_grp_req #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_mode,
  input  logic [GW-1:0] rise,
  input  logic [GW-1:0] fall,
  input  logic [GW-1:0] mask,
  input  logic [GW-1:0] val_next,
  input  logic [GW-1:0] cause_cur,
  input  logic          cause_wr,
  input  logic [GW-1:0] cause_wd,
  output logic          req
);
  logic set_ev, lvl_drop, edge_drop;

  assign set_ev    = |(rise & mask);
  assign lvl_drop  = lvl_mode && (|fall) && (val_next == '0);
  assign edge_drop = !lvl_mode && cause_wr && ((cause_cur ^ cause_wd) != '0)
                     && (cause_wd == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                       req <= 1'b0;
    else if (set_ev)                  req <= 1'b1;
    else if (lvl_drop || edge_drop)   req <= 1'b0;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int GRP_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PINS-1:0]         pin_in,
  output logic [N_PINS-1:0]         pin_out,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [N_PINS-1:0]         reg_wdata,
  output logic [N_PINS-1:0]         reg_rdata,
  output logic [N_PINS/GRP_W-1:0]   grp_irq
);
  localparam int N_GRP = N_PINS / GRP_W;

  logic [N_PINS-1:0] dir_q, pol_q, val_q, cause_q, mask_q;
  logic [N_PINS-1:0] sync_q, lvl, rise_vec, fall_vec, val_d, cause_d;
  logic              lvl_mode_q;
  logic              cause_wr;
  out_op_e           op;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign lvl      = sync_q ^ pol_q;
  assign rise_vec = ~dir_q & lvl & ~val_q;
  assign fall_vec = ~dir_q & ~lvl & val_q;
  assign cause_wr = reg_we && (reg_addr == A_CAUSE);

  always_comb begin
    op = OP_NONE;
    if (reg_we) begin
      case (reg_addr)
        A_VAL:   op = OP_LOAD;
        A_SET:   op = OP_SET;
        A_CLR:   op = OP_CLR;
        default: op = OP_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign val_d[i] = dir_q[i] ? out_bit_next(val_q[i], reg_wdata[i], op) : lvl[i];
  end

  assign cause_d = (cause_wr ? reg_wdata : cause_q) | rise_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q      <= '0;
      pol_q      <= '0;
      val_q      <= '0;
      cause_q    <= '0;
      mask_q     <= '0;
      lvl_mode_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      cause_q <= cause_d;
      if (reg_we) begin
        case (reg_addr)
          A_DIR:          dir_q      <= reg_wdata;
          A_POL:          pol_q      <= reg_wdata;
          A_MSKA, A_MSKB: mask_q     <= reg_wdata;
          A_CTRL:         lvl_mode_q <= reg_wdata[MODE_BIT];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    gpio_grp_req #(.GW(GRP_W)) u_req (
      .clk(clk), .rst_n(rst_n), .lvl_mode(lvl_mode_q),
      .rise(rise_vec[g*GRP_W +: GRP_W]),
      .fall(fall_vec[g*GRP_W +: GRP_W]),
      .mask(mask_q[g*GRP_W +: GRP_W]),
      .val_next(val_d[g*GRP_W +: GRP_W]),
      .cause_cur(cause_q[g*GRP_W +: GRP_W]),
      .cause_wr(cause_wr),
      .cause_wd(reg_wdata[g*GRP_W +: GRP_W]),
      .req(grp_irq[g])
    );
  end

  always_comb begin
    case (reg_addr)
      A_DIR:          reg_rdata = dir_q;
      A_POL:          reg_rdata = pol_q;
      A_VAL:          reg_rdata = val_q;
      A_CAUSE:        reg_rdata = cause_q;
      A_MSKA, A_MSKB: reg_rdata = mask_q;
      A_CTRL:         reg_rdata = N_PINS'(ctrl_word(lvl_mode_q));
      default:        reg_rdata = '0;
    endcase
  end

  assign pin_out = val_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int GRP_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_we,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [N_PINS-1:0]       reg_wdata,
  input logic [N_PINS-1:0]       reg_rdata,
  input logic [N_PINS-1:0]       pin_out,
  input logic [N_PINS/GRP_W-1:0] grp_irq,
  input logic [N_PINS-1:0]       dir_q,
  input logic [N_PINS-1:0]       mask_q,
  input logic [N_PINS-1:0]       cause_q,
  input logic [N_PINS-1:0]       rise_vec,
  input logic                    lvl_mode_q
);
  localparam int N_GRP = N_PINS / GRP_W;

  p_val_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_VAL) |=> ((pin_out & dir_q) == ($past(reg_wdata) & dir_q)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR) |=>
      ((pin_out & dir_q) == ($past(pin_out) & ~$past(reg_wdata) & dir_q)));

  p_ctrl_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[31:16] == 16'h11FF &&
                               reg_rdata[MODE_BIT] == lvl_mode_q));

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    p_masked_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_vec[g*GRP_W +: GRP_W] & mask_q[g*GRP_W +: GRP_W])) |=> grp_irq[g]);

    p_edge_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_CAUSE && !lvl_mode_q &&
       reg_wdata[g*GRP_W +: GRP_W] == '0 && cause_q[g*GRP_W +: GRP_W] != '0 &&
       rise_vec[g*GRP_W +: GRP_W] == '0) |=> !grp_irq[g]);

    p_lvl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode_q && grp_irq[g] && reg_we && reg_addr == A_CAUSE &&
       rise_vec[g*GRP_W +: GRP_W] == '0 &&
       (~dir_q[g*GRP_W +: GRP_W] & pin_out[g*GRP_W +: GRP_W]) != '0 &&
       $stable(pin_out)) |=> grp_irq[g] || !$stable(pin_out));
  end
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_out(pin_out),
  .grp_irq(grp_irq), .dir_q(dir_q), .mask_q(mask_q), .cause_q(cause_q),
  .rise_vec(rise_vec), .lvl_mode_q(lvl_mode_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CYC = 10;
  localparam int NV  = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  grp_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CYC/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .grp_irq(grp_irq)
  );

  // entry: {write, requirement number, address, data or expected read}
  localparam logic [40:0] TBL [0:NV-1] = '{
    {1'b1, 4'd2,  4'd0, 32'h0000_FFFF},  // R2 low half outputs
    {1'b1, 4'd2,  4'd2, 32'hA5A5_A5A5},
    {1'b0, 4'd2,  4'd2, 32'h0000_A5A5},
    {1'b1, 4'd3,  4'd3, 32'hFFFF_00F0},  // R3 set alias
    {1'b0, 4'd3,  4'd3, 32'h0000_0000},
    {1'b0, 4'd3,  4'd2, 32'h0000_A5F5},
    {1'b1, 4'd3,  4'd4, 32'h000F_0F00},  // R3 clear alias
    {1'b0, 4'd3,  4'd4, 32'h0000_0000},
    {1'b0, 4'd3,  4'd2, 32'h0000_A0F5},
    {1'b1, 4'd11, 4'd6, 32'h1234_5678},  // R11 mask alias
    {1'b0, 4'd11, 4'd7, 32'h1234_5678},
    {1'b1, 4'd11, 4'd7, 32'h0000_BEEF},
    {1'b0, 4'd11, 4'd6, 32'h0000_BEEF},
    {1'b1, 4'd11, 4'd6, 32'h0000_0000},
    {1'b0, 4'd9,  4'd8, 32'h11FF_0000},  // R9 control word
    {1'b1, 4'd9,  4'd8, 32'hFFFF_FFFF},
    {1'b0, 4'd9,  4'd8, 32'h11FF_0400},
    {1'b1, 4'd9,  4'd8, 32'h0000_0000},
    {1'b0, 4'd9,  4'd8, 32'h11FF_0000},
    {1'b1, 4'd10, 4'd5, 32'hDEAD_BEEF},  // R10 replace
    {1'b0, 4'd10, 4'd5, 32'hDEAD_BEEF},
    {1'b1, 4'd10, 4'd5, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, r); check("R1 dir", r, 32'h0);
    rd(4'd1, r); check("R1 pol", r, 32'h0);
    rd(4'd2, r); check("R1 val", r, 32'h0);
    rd(4'd5, r); check("R1 cause", r, 32'h0);
    rd(4'd6, r); check("R1 mask", r, 32'h0);
    rd(4'd8, r); check("R1 mode", r, 32'h11FF_0000);
    check("R1 out", pin_out, 32'h0);
    check("R1 irq", {28'h0, grp_irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (TBL[k][40]) wr(TBL[k][35:32], TBL[k][31:0]);
      else begin
        rd(TBL[k][35:32], r);
        check($sformatf("R%0d table %0d", TBL[k][39:36], k), r, TBL[k][31:0]);
      end
    end

    // R4 polarity inversion; R7 unmasked rise sets cause without request
    wr(4'd1, 32'hFFFF_0000);
    wait_cyc(4);
    rd(4'd2, r); check("R4 inverted inputs", r, 32'hFFFF_A0F5);
    rd(4'd5, r); check("R7 cause set", r, 32'hFFFF_0000);
    check("R7 no request", {28'h0, grp_irq}, 32'h0);
    wr(4'd1, 32'h0);
    wait_cyc(4);
    wr(4'd5, 32'h0);

    // R5 latency and R6 masked rise raises group 3
    wr(4'd6, 32'h0100_0000);
    @(negedge clk);
    pin_in[24] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(4'd2, r); check("R5 not after two edges", r & 32'h0100_0000, 32'h0);
    check("R5 no request yet", {28'h0, grp_irq}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rd(4'd2, r); check("R5 after three edges", r & 32'h0100_0000, 32'h0100_0000);
    rd(4'd5, r); check("R6 cause bit", r, 32'h0100_0000);
    check("R6 group request", {28'h0, grp_irq}, 32'h8);

    // R10 edge mode sticky and release rule
    pin_in[24] = 1'b0;
    wait_cyc(4);
    check("R10 sticky after fall", {28'h0, grp_irq}, 32'h8);
    wr(4'd5, 32'h0200_0000);
    check("R10 nonzero rewrite keeps", {28'h0, grp_irq}, 32'h8);
    wr(4'd5, 32'h0);
    check("R10 zero rewrite releases", {28'h0, grp_irq}, 32'h0);

    // R8 level-follow release
    wr(4'd8, 32'h0000_0400);
    wr(4'd6, 32'h0300_0000);
    pin_in[24] = 1'b1; pin_in[25] = 1'b1;
    wait_cyc(4);
    check("R8 raised", {28'h0, grp_irq}, 32'h8);
    pin_in[24] = 1'b0;
    wait_cyc(4);
    check("R8 held by other pin", {28'h0, grp_irq}, 32'h8);
    pin_in[25] = 1'b0;
    wait_cyc(4);
    check("R8 dropped", {28'h0, grp_irq}, 32'h0);

    // R12 cause write has no release effect in level mode
    pin_in[24] = 1'b1;
    wait_cyc(4);
    wr(4'd5, 32'h0);
    check("R12 request kept", {28'h0, grp_irq}, 32'h8);
    pin_in[24] = 1'b0;
    wait_cyc(4);
    check("R12 drops on fall", {28'h0, grp_irq}, 32'h0);

    // R2 and R3 input pins ignore writes
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, r); check("R2 inputs ignore load", r, 32'h0000_FFFF);
    wr(4'd3, 32'hFFFF_0000);
    rd(4'd2, r); check("R3 inputs ignore set", r, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'h0000_FFFF);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    rd(4'd0, r); check("R1 dir after reset", r, 32'h0);
    rd(4'd8, r); check("R1 mode after reset", r, 32'h11FF_0000);
    check("R1 out after reset", pin_out, 32'h0);
    rst_n = 1'b1;
    wait_cyc(2);

    finish_up();
  end
endmodule